// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives a single DRAM bank. Each request carries a row, a column and a write flag. The block turns the request into the shortest legal series of bank commands, using the bank's present condition and the row it holds open. If the bank holds the requested row, one column command is enough. If the bank is closed, the block first activates the row. If a different row is open, the block closes it, activates the new row, and then issues the column command. The column command is always the last command of a request. It carries the completion strobe and a flag that says whether the request found its row already open.

The `close_page` input selects the page policy. When it is high, the bank is closed right after every column command, as soon as the column-to-precharge spacing allows. When it is low, the row stays open until a request for another row arrives. Three delay inputs set the minimum spacing, in cycles, from precharge to activate, from activate to column, and from column to precharge. A delay of 0 acts as 1.

The controller has five named states:
- WAIT: ready for a request.
- PRE: closing the bank for a request that missed.
- ACT: opening the requested row.
- COL: issuing the column command.
- AUTOPRE: the close that the close-page policy adds after a column command.

The transitions are:
- WAIT goes to COL on a hit, to PRE on a miss with a row open, and to ACT when the bank is closed.
- PRE goes to ACT.
- ACT goes to COL.
- COL goes to AUTOPRE under close-page policy and to WAIT under open-page policy.
- AUTOPRE goes to WAIT.

A state that must respect a spacing holds until the matching delay counter reaches zero.

Top module: `bank_cmd_seq`

## Requirements
- R1: After reset the bank is closed and no row is open. `req_ready` is 1, `cmd` is 0 and `done` is 0. The first request therefore gets an activate followed by a column command, and `done_hit` is 0.
- R2: A precharge (cmd code 1) is issued only while the bank is open, and the bank is closed afterwards.
- R3: An activate (cmd code 2) is issued only while the bank is closed. It shows the request row on `cmd_row`, and that row is open afterwards.
- R4: A column command (cmd code 3) is issued only while the bank is open, and the bank stays open. It shows the request column on `cmd_col` and the write flag on `cmd_write`. `done` is 1 in exactly that cycle, and it is the last command of the request. Code 0 means no command.
- R5: A request for the row that is already open gets only a column command, and `done_hit` is 1.
- R6: A request for a row other than the open one gets precharge, then activate, then column command, and `done_hit` is 0.
- R7: With `close_page` = 1, a precharge follows every column command exactly max(t_col_pre,1) cycles later. `req_ready` stays 0 until the cycle after that precharge.
- R8: With `close_page` = 0, no precharge follows a column command while no request is pending, and the row stays open.
- R9: Each command is issued in the first cycle that satisfies two conditions: it is at least one cycle after the previous command of the same request (or after acceptance), and it meets its spacing. The spacing is max(t_pre_act,1) from the last precharge to an activate, max(t_act_col,1) from the last activate to a column command, and max(t_col_pre,1) from the last column command to a precharge.
- R10: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. No command is issued in the cycle of acceptance, and `req_ready` stays 0 until the request's column command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_page | input | 1 | 1 = close after every access, 0 = keep row open |
| t_pre_act | input | DLY_W | Precharge-to-activate spacing |
| t_act_col | input | DLY_W | Activate-to-column spacing |
| t_col_pre | input | DLY_W | Column-to-precharge spacing |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd | output | 2 | Command code: 0 none, 1 precharge, 2 activate, 3 column |
| cmd_row | output | ROW_W | Row address for the command |
| cmd_col | output | COL_W | Column address for the command |
| cmd_write | output | 1 | Write flag, set only with a column command |
| done | output | 1 | Completion strobe, coincides with the column command |
| done_hit | output | 1 | The completed request found its row already open |

## Verification
The bench builds the block with a 4-bit row, a 3-bit column and 4-bit delay inputs. It sweeps every combination of the three delays from 0 to 3 under both page policies, which is 128 configurations. That range covers the zero-treated-as-one case and spacings that either stall a state or expire before the state is entered. Each configuration runs a row pattern that produces hits, misses with a row open, and accesses to a closed bank, including the highest row. The expected command sequence and the cycle of every command come from the bench's own bank model.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_COL = 2'd3
    } bank_cmd_e;

    typedef enum logic [2:0] {
        SQ_WAIT,
        SQ_PRE,
        SQ_ACT,
        SQ_COL,
        SQ_AUTOPRE
    } seq_state_e;

    localparam int TIMER_CNT = 3;
    localparam int TI_PA = 0;
    localparam int TI_AC = 1;
    localparam int TI_CP = 2;

endpackage

// File: rtl/spacing_timer.sv
module spacing_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    output logic             expired
);
    logic [DLY_W-1:0] cnt;

    // Loading d lets the next command through d cycles later (0 acts as 1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (dly == '0) ? '0 : dly - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/row_tracker.sv
module row_tracker #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_pre,
    input  logic             do_act,
    input  logic [ROW_W-1:0] act_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             is_open,
    output logic             probe_hit
);
    logic [ROW_W-1:0] held_row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open  <= 1'b0;
            held_row <= '0;
        end else if (do_act) begin
            is_open  <= 1'b1;
            held_row <= act_row;
        end else if (do_pre) begin
            is_open  <= 1'b0;
        end
    end

    assign probe_hit = is_open && (held_row == probe_row);
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
    import bank_seq_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int COL_W = 10,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_page,
    input  logic [DLY_W-1:0] t_pre_act,
    input  logic [DLY_W-1:0] t_act_col,
    input  logic [DLY_W-1:0] t_col_pre,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_write,
    output logic [1:0]       cmd,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             cmd_write,
    output logic             done,
    output logic             done_hit
);
    seq_state_e st, st_nxt;
    bank_cmd_e  cmd_e;

    logic [ROW_W-1:0] q_row;
    logic [COL_W-1:0] q_col;
    logic             q_wr;
    logic             q_hit;

    logic             bank_open;
    logic             probe_hit;
    logic             accept;

    logic [TIMER_CNT-1:0] tm_load;
    logic [TIMER_CNT-1:0] tm_expired;
    logic [DLY_W-1:0]     tm_dly [TIMER_CNT];

    assign tm_dly[TI_PA] = t_pre_act;
    assign tm_dly[TI_AC] = t_act_col;
    assign tm_dly[TI_CP] = t_col_pre;

    generate
        for (genvar gi = 0; gi < TIMER_CNT; gi++) begin : g_timer
            spacing_timer #(.DLY_W(DLY_W)) u_tm (
                .clk     (clk),
                .rst_n   (rst_n),
                .load    (tm_load[gi]),
                .dly     (tm_dly[gi]),
                .expired (tm_expired[gi])
            );
        end
    endgenerate

    row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_pre    (cmd_e == CMD_PRE),
        .do_act    (cmd_e == CMD_ACT),
        .act_row   (q_row),
        .probe_row (req_row),
        .is_open   (bank_open),
        .probe_hit (probe_hit)
    );

    assign accept = req_ready && req_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_WAIT;
        end else begin
            st <= st_nxt;
        end
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_row <= '0;
            q_col <= '0;
            q_wr  <= 1'b0;
            q_hit <= 1'b0;
        end else if (accept) begin
            q_row <= req_row;
            q_col <= req_col;
            q_wr  <= req_write;
            q_hit <= probe_hit;
        end
    end

    // Next state and command outputs
    always_comb begin
        st_nxt    = st;
        cmd_e     = CMD_NOP;
        req_ready = 1'b0;
        done      = 1'b0;
        tm_load   = '0;
        unique case (st)
            SQ_WAIT: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (probe_hit) begin
                        st_nxt = SQ_COL;
                    end else if (bank_open) begin
                        st_nxt = SQ_PRE;
                    end else begin
                        st_nxt = SQ_ACT;
                    end
                end
            end
            SQ_PRE: begin
                if (tm_expired[TI_CP]) begin
                    cmd_e          = CMD_PRE;
                    tm_load[TI_PA] = 1'b1;
                    st_nxt         = SQ_ACT;
                end
            end
            SQ_ACT: begin
                if (tm_expired[TI_PA]) begin
                    cmd_e          = CMD_ACT;
                    tm_load[TI_AC] = 1'b1;
                    st_nxt         = SQ_COL;
                end
            end
            SQ_COL: begin
                if (tm_expired[TI_AC]) begin
                    cmd_e          = CMD_COL;
                    done           = 1'b1;
                    tm_load[TI_CP] = 1'b1;
                    st_nxt         = close_page ? SQ_AUTOPRE : SQ_WAIT;
                end
            end
            SQ_AUTOPRE: begin
                if (tm_expired[TI_CP]) begin
                    cmd_e          = CMD_PRE;
                    tm_load[TI_PA] = 1'b1;
                    st_nxt         = SQ_WAIT;
                end
            end
            default: begin
                st_nxt = SQ_WAIT;
            end
        endcase
    end

    assign cmd       = cmd_e;
    assign cmd_row   = q_row;
    assign cmd_col   = q_col;
    assign cmd_write = q_wr && (cmd_e == CMD_COL);
    assign done_hit  = done && q_hit;
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk
    import bank_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       req_ready,
    input logic       req_valid,
    input logic       done,
    input logic       close_page,
    input logic       bank_open
);
    // R2
    pre_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |-> bank_open);

    // R2
    pre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PRE |=> !bank_open);

    // R3
    act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ACT |-> !bank_open);

    // R3
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_ACT |=> bank_open);

    // R4
    col_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_COL |-> bank_open);

    // R7
    close_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && close_page) |=> !req_ready);

    // R10
    no_cmd_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |-> cmd == CMD_NOP);
endmodule

bind bank_cmd_seq bank_cmd_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .done       (done),
    .close_page (close_page),
    .bank_open  (bank_open)
);

// File: tb/bank_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module bank_cmd_seq_tb_top;
    localparam int ROW_W = 4;
    localparam int COL_W = 3;
    localparam int DLY_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             close_page = 1'b0;
    logic [DLY_W-1:0] t_pre_act = '0;
    logic [DLY_W-1:0] t_act_col = '0;
    logic [DLY_W-1:0] t_col_pre = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_write = 1'b0;
    logic [1:0]       cmd;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic             cmd_write;
    logic             done;
    logic             done_hit;

    bank_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .close_page(close_page),
        .t_pre_act(t_pre_act), .t_act_col(t_act_col), .t_col_pre(t_col_pre),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_col(req_col), .req_write(req_write), .cmd(cmd), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_write(cmd_write), .done(done), .done_hit(done_hit)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench bank model
    bit m_open = 0;
    int m_row = 0;
    int last_pre = -100;
    int last_act = -100;
    int last_col = -100;

    function automatic int gap(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic run_req(input int row, input int col, input bit wr);
        int acc;
        int entry;
        int seen;
        int nexp;
        int kinds [3];
        int expt;
        bit hit;
        @(negedge clk);
        req_valid = 1'b1;
        req_row   = row[ROW_W-1:0];
        req_col   = col[COL_W-1:0];
        req_write = wr;
        while (!req_ready) @(negedge clk);
        acc = cyc;
        hit = m_open && (m_row == row);
        if (hit) begin
            nexp = 1; kinds[0] = 3;
        end else if (m_open) begin
            nexp = 3; kinds[0] = 1; kinds[1] = 2; kinds[2] = 3;
        end else begin
            nexp = 2; kinds[0] = 2; kinds[1] = 3;
        end
        @(negedge clk);
        req_valid = 1'b0;
        entry = acc + 1;
        seen = 0;
        for (int k = 0; k < 100; k++) begin
            if (cmd != 2'd0) begin
                // R10: still busy while the request is in flight
                check(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
                if (seen < nexp) begin
                    check(int'(cmd) == kinds[seen], "R5/R6 command order", cmd, kinds[seen]);
                end
                if (cmd == 2'd1) begin
                    check(m_open == 1'b1, "R2 precharge while open", m_open, 1);
                    expt = mx(entry, last_col + gap(int'(t_col_pre)));
                    check(cyc == expt, "R9 precharge cycle", cyc, expt);
                    m_open = 0; last_pre = cyc;
                end else if (cmd == 2'd2) begin
                    check(m_open == 1'b0, "R3 activate while closed", m_open, 0);
                    check(int'(cmd_row) == row, "R3 activate row", cmd_row, row);
                    expt = mx(entry, last_pre + gap(int'(t_pre_act)));
                    check(cyc == expt, "R9 activate cycle", cyc, expt);
                    m_open = 1; m_row = row; last_act = cyc;
                end else begin
                    check(m_open == 1'b1, "R4 column while open", m_open, 1);
                    check(int'(cmd_col) == col, "R4 column address", cmd_col, col);
                    check(cmd_write == wr, "R4 write flag", cmd_write, wr);
                    check(done == 1'b1, "R4 done with column", done, 1);
                    check(done_hit == hit, "R5/R6 hit flag", done_hit, hit);
                    expt = mx(entry, last_act + gap(int'(t_act_col)));
                    check(cyc == expt, "R9 column cycle", cyc, expt);
                    last_col = cyc;
                end
                entry = cyc + 1;
                seen++;
                if (cmd == 2'd3) break;
            end else if (done) begin
                check(0, "R4 done without column", 1, 0);
            end
            @(negedge clk);
        end
        check(seen == nexp, "R4/R5/R6 command count", seen, nexp);
        if (close_page) begin
            @(negedge clk);
            for (int k = 0; k < 40 && cmd == 2'd0; k++) begin
                check(req_ready == 1'b0, "R7 ready low before close", req_ready, 0);
                @(negedge clk);
            end
            expt = last_col + gap(int'(t_col_pre));
            check(cmd == 2'd1, "R7 automatic precharge", cmd, 1);
            check(cyc == expt, "R7 precharge cycle", cyc, expt);
            m_open = 0; last_pre = cyc;
            @(negedge clk);
            check(req_ready == 1'b1, "R7 ready after close", req_ready, 1);
        end else begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(cmd == 2'd0, "R8 no precharge when open page", cmd, 0);
            end
        end
    endtask

    initial begin
        int rows [6];
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(cmd == 2'd0, "R1 no command after reset", cmd, 0);
        check(done == 1'b0, "R1 done low after reset", done, 0);
        // R1 first request on row 0 must see a closed bank
        run_req(0, 5, 1'b0);
        check(last_act > 0, "R1 first request activates", last_act > 0, 1);

        rows[0] = 1; rows[1] = 1; rows[2] = 15; rows[3] = 15; rows[4] = 0; rows[5] = 1;
        for (int pol = 0; pol < 2; pol++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    for (int c = 0; c < 4; c++) begin
                        @(negedge clk);
                        close_page = pol[0];
                        t_pre_act  = a[DLY_W-1:0];
                        t_act_col  = b[DLY_W-1:0];
                        t_col_pre  = c[DLY_W-1:0];
                        repeat (6) @(negedge clk);
                        for (int i = 0; i < 6; i++) begin
                            run_req(rows[i], (i + a + c) % 8, i[0]);
                        end
                    end
                end
            end
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule